// File: doc/BRIEF.md
# Request-Triggered Serial Result Sender

This block sits between a host and a measurement core. The host asks for a reading by pulling an active-low request line low. Once that request has been qualified, the block pulses a start strobe to the core. It then waits for the 16-bit result on a valid/ready stream. After that it acts as the serial clock master and sends the result as two bytes to the host. Each byte is framed by an active-low data-ready line.

Between the two bytes, data-ready is driven high for a gap set by an 8-bit setting. Clock polarity and the clock half-period are configuration inputs, and the half-period is clamped to a floor so the serial clock never runs faster than allowed.

The data and data-ready lines come out as value/enable pairs, so the pads can float them. If the host still holds its request low when the result arrives, the block enters setup mode and sends nothing.

The result stream follows these back-pressure rules:
- `res_ready` is high only while the block is waiting for a result.
- The core must hold `res_valid` and `res_data` steady until a cycle in which both `res_valid` and `res_ready` are high.
- A result offered at any other time stays pending and is not consumed.

Top module: `req_spi_sender`

## Requirements
- R1: After reset, `drdy_oe`, `sdo_oe`, `meas_start`, `res_ready` and `setup_mode` are 0, and `sck` equals `cfg_cpol`.
- R2: Holding `req_n` low for at least REQ_MIN_CYC cycles produces exactly one `meas_start` pulse. A low pulse much shorter than that produces none.
- R3: `res_ready` is 1 only while a result is awaited. A result is taken in a cycle with `res_valid` and `res_ready` both 1.
- R4: If `req_n` is still low when the result is taken, `setup_mode` goes to 1 and stays there until reset. `drdy_oe` and `sdo_oe` are never driven in that case.
- R5: Two bytes are sent, bits 15..8 first and then bits 7..0, each byte MSB first. `drdy_oe`=1 and `drdy_n`=0 throughout each byte.
- R6: Between the bytes, `drdy_oe`=1 and `drdy_n`=1 for (10+4*`cfg_mls`)*GAP_TICK_CYC cycles, within one tick.
- R7: After the low byte, `drdy_oe` and `sdo_oe` return to 0. `sdo_oe` is 1 only inside a byte.
- R8: With `cfg_cpol`=0, `sck` rests low and `sdo` changes only on rising `sck` edges. With `cfg_cpol`=1, `sck` rests high and `sdo` changes only on falling edges. Each byte has 8 clock pulses.
- R9: Every `sck` half-period within a byte lasts max(`cfg_half_div`, MIN_HALF_CYC) cycles.
- R10: A request made while a transfer is in progress causes no new `meas_start`, and the frame in flight is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_n | input | 1 | Active-low host request (asynchronous) |
| cfg_cpol | input | 1 | Serial clock rest level |
| cfg_mls | input | 8 | Inter-byte gap setting |
| cfg_half_div | input | DIV_W | Serial clock half-period in cycles |
| meas_start | output | 1 | One-cycle acquisition start strobe |
| res_valid | input | 1 | Result offered by core |
| res_ready | output | 1 | Block accepts result |
| res_data | input | 16 | Measurement result |
| setup_mode | output | 1 | Sticky setup-mode flag |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data value |
| sdo_oe | output | 1 | Serial data drive enable |
| drdy_n | output | 1 | Data-ready value (active low) |
| drdy_oe | output | 1 | Data-ready drive enable |

## Verification
- **Start strobe:** `meas_start` is due REQ_MIN_CYC+2 cycles after `req_n` falls. The two extra cycles come from the synchronizer, and the strobe is registered.
- **First byte:** data-ready falls one cycle after the result handshake. The first `sck` edge follows one half-period later, and each byte lasts 17 half-periods.
- **Gap:** the gap begins the cycle after the first byte's last half-period.
- **How the checks keep to this:** the bench samples on the falling clock edge. It counts cycles between observed transitions, so half-periods are checked exactly and gaps to within one tick, rather than at fixed absolute times.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ACQ, ST_HIBYTE, ST_GAP, ST_LOBYTE, ST_SETUP
  } rsr_state_e;

  localparam int BYTE_W   = 8;
  localparam int RESULT_W = 16;
  localparam int MLS_W    = 8;
endpackage

// File: rtl/rsr_req_filter.sv
module rsr_req_filter #(
  parameter int MIN_CYC = 6000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  output logic req_low,
  output logic fire
);
  localparam int CW = $clog2(MIN_CYC + 1);
  logic s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= 1'b1;
      s2  <= 1'b1;
      cnt <= '0;
    end else begin
      s1 <= req_n;
      s2 <= s1;
      if (s2) cnt <= '0;
      else if (cnt != CW'(MIN_CYC)) cnt <= cnt + 1'b1;
    end
  end

  assign req_low = ~s2;
  assign fire    = ~s2 && (cnt == CW'(MIN_CYC - 1));

  assert_single_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/rsr_gap_timer.sv
module rsr_gap_timer #(
  parameter int TICK_CYC = 167,
  parameter int MLS_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [MLS_W-1:0] mls,
  output logic             busy,
  output logic             done
);
  localparam int TW = MLS_W + 3;
  localparam int PW = $clog2(TICK_CYC + 1);
  logic [TW-1:0] total, tcnt;
  logic [PW-1:0] pre;

  assign total = TW'(10) + {1'b0, mls, 2'b00};
  assign done  = busy && (pre == PW'(TICK_CYC - 1)) && (tcnt == total - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pre  <= '0;
      tcnt <= '0;
    end else if (start) begin
      busy <= 1'b1;
      pre  <= '0;
      tcnt <= '0;
    end else if (busy) begin
      if (pre == PW'(TICK_CYC - 1)) begin
        pre <= '0;
        if (tcnt == total - 1'b1) busy <= 1'b0;
        else tcnt <= tcnt + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  assert_gap_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tcnt < total));
endmodule

// File: rtl/rsr_byte_tx.sv
module rsr_byte_tx #(
  parameter int DIV_W    = 16,
  parameter int MIN_HALF = 2500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       byte_in,
  input  logic [DIV_W-1:0] half_div,
  output logic             busy,
  output logic             done,
  output logic             sck_lvl,
  output logic             sdo
);
  localparam int EDGES = 16;
  logic [DIV_W-1:0] half_eff, hcnt;
  logic [4:0]       ecnt;
  logic [7:0]       sh;
  logic             tick;

  assign half_eff = (half_div < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : half_div;
  assign tick     = busy && (hcnt == half_eff - 1'b1);
  assign done     = tick && (ecnt == 5'(EDGES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; hcnt <= '0; ecnt <= '0;
      sck_lvl <= 1'b0; sh <= '0; sdo <= 1'b0;
    end else if (start) begin
      busy <= 1'b1; hcnt <= '0; ecnt <= '0;
      sck_lvl <= 1'b0; sh <= byte_in; sdo <= 1'b0;
    end else if (busy) begin
      if (tick) begin
        hcnt <= '0;
        if (ecnt == 5'(EDGES)) begin
          busy <= 1'b0;
        end else begin
          sck_lvl <= ~sck_lvl;
          if (!ecnt[0]) begin
            sdo <= sh[7];
            sh  <= {sh[6:0], 1'b0};
          end
          ecnt <= ecnt + 1'b1;
        end
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  assert_sck_rests_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck_lvl);
  assert_data_on_leading_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && $past(busy) && !$stable(sdo)) |-> sck_lvl);
endmodule

// File: rtl/req_spi_sender.sv
module req_spi_sender
  import rsr_pkg::*;
#(
  parameter int REQ_MIN_CYC  = 6000,
  parameter int GAP_TICK_CYC = 167,
  parameter int MIN_HALF_CYC = 2500,
  parameter int DIV_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_n,
  input  logic             cfg_cpol,
  input  logic [7:0]       cfg_mls,
  input  logic [DIV_W-1:0] cfg_half_div,
  output logic             meas_start,
  input  logic             res_valid,
  output logic             res_ready,
  input  logic [15:0]      res_data,
  output logic             setup_mode,
  output logic             sck,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             drdy_n,
  output logic             drdy_oe
);
  rsr_state_e state;
  logic req_low, fire, accept, tx_start, tx_busy, tx_done, sck_lvl;
  logic gap_busy, gap_done, gap_start;
  logic [BYTE_W-1:0] lo_q, tx_byte;

  rsr_req_filter #(.MIN_CYC(REQ_MIN_CYC)) i_filt (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .req_low(req_low), .fire(fire));

  assign accept    = (state == ST_ACQ) && res_valid;
  assign tx_start  = (accept && !req_low) || ((state == ST_GAP) && gap_done);
  assign tx_byte   = (state == ST_ACQ) ? res_data[15:8] : lo_q;
  assign gap_start = (state == ST_HIBYTE) && tx_done;

  rsr_byte_tx #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF_CYC)) i_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .byte_in(tx_byte),
    .half_div(cfg_half_div), .busy(tx_busy), .done(tx_done),
    .sck_lvl(sck_lvl), .sdo(sdo));

  rsr_gap_timer #(.TICK_CYC(GAP_TICK_CYC), .MLS_W(MLS_W)) i_gap (
    .clk(clk), .rst_n(rst_n), .start(gap_start), .mls(cfg_mls),
    .busy(gap_busy), .done(gap_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      meas_start <= 1'b0;
      setup_mode <= 1'b0;
      lo_q       <= '0;
    end else begin
      meas_start <= (state == ST_IDLE) && fire;
      case (state)
        ST_IDLE:   if (fire) state <= ST_ACQ;
        ST_ACQ:    if (accept) begin
                     lo_q <= res_data[7:0];
                     if (req_low) begin
                       state      <= ST_SETUP;
                       setup_mode <= 1'b1;
                     end else begin
                       state <= ST_HIBYTE;
                     end
                   end
        ST_HIBYTE: if (tx_done) state <= ST_GAP;
        ST_GAP:    if (gap_done) state <= ST_LOBYTE;
        ST_LOBYTE: if (tx_done) state <= ST_IDLE;
        default:   state <= ST_SETUP;
      endcase
    end
  end

  assign res_ready = (state == ST_ACQ);
  assign drdy_oe   = (state == ST_HIBYTE) || (state == ST_GAP) || (state == ST_LOBYTE);
  assign drdy_n    = (state == ST_GAP);
  assign sdo_oe    = tx_busy;
  assign sck       = cfg_cpol ^ sck_lvl;

  assert_start_enters_acq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    meas_start |-> (state == ST_ACQ));
  assert_setup_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    setup_mode |-> (!drdy_oe && !sdo_oe));
  assert_sdo_inside_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> (drdy_oe && !drdy_n));
  assert_gap_drives_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gap_busy |-> (drdy_oe && drdy_n));
  assert_no_retrigger_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> !meas_start || $past(state == ST_IDLE));
endmodule

// File: tb/test_req_spi_sender.sv
module test_req_spi_sender;
  localparam int REQ_MIN  = 16;
  localparam int GAP_TICK = 3;
  localparam int MIN_HALF = 4;
  localparam int ACQ_DLY  = 40;

  logic clk = 1'b0, rst_n = 1'b0, req_n = 1'b1, cfg_cpol = 1'b0;
  logic [7:0] cfg_mls = 8'd0;
  logic [15:0] cfg_half_div = 16'd4, res_data = 16'd0;
  logic res_valid = 1'b0;
  logic meas_start, res_ready, setup_mode, sck, sdo, sdo_oe, drdy_n, drdy_oe;

  always #2.5 clk = ~clk;

  req_spi_sender #(.REQ_MIN_CYC(REQ_MIN), .GAP_TICK_CYC(GAP_TICK),
    .MIN_HALF_CYC(MIN_HALF), .DIV_W(16)) i_req_spi_sender (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .cfg_cpol(cfg_cpol), .cfg_mls(cfg_mls),
    .cfg_half_div(cfg_half_div), .meas_start(meas_start), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .setup_mode(setup_mode), .sck(sck),
    .sdo(sdo), .sdo_oe(sdo_oe), .drdy_n(drdy_n), .drdy_oe(drdy_oe));

  int errors = 0, checks = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // stub measurement core
  logic [15:0] stub_word = 16'd0;
  int stub_cnt = -1;
  bit pend = 0, ready_at_valid = 0;
  always @(negedge clk) begin
    if (meas_start) stub_cnt = ACQ_DLY;
    else if (stub_cnt > 0) stub_cnt--;
    else if (stub_cnt == 0) begin
      res_valid = 1'b1; res_data = stub_word; stub_cnt = -1;
    end
    if (res_valid && res_ready) begin
      pend = 1; ready_at_valid = 1;
    end else if (pend) begin
      res_valid = 1'b0; pend = 0;
    end
  end

  // host-side monitor
  logic prev_sck = 1'b0, prev_sdo = 1'b0, prev_oe = 1'b0, prev_low = 1'b0;
  logic [15:0] rx;
  int nbits, nbytes, gap_cnt, ccnt, hmin, hmax, bad_sdo, mstarts, pulses;
  bit drive_seen;
  task automatic clear_stats();
    rx = 0; nbits = 0; nbytes = 0; gap_cnt = 0; ccnt = 0; hmin = 1 << 30; hmax = 0;
    bad_sdo = 0; mstarts = 0; pulses = 0; drive_seen = 0; ready_at_valid = 0;
  endtask
  always @(negedge clk) begin
    logic low;
    low = drdy_oe && !drdy_n;
    if (meas_start) mstarts++;
    if (drdy_oe) drive_seen = 1;
    if (drdy_oe && drdy_n) gap_cnt++;
    if (low && !prev_low) begin nbytes++; ccnt = 0; end
    else if (low) begin
      ccnt++;
      if (sck != prev_sck) begin
        if (ccnt < hmin) hmin = ccnt;
        if (ccnt > hmax) hmax = ccnt;
        ccnt = 0;
        if (sck == cfg_cpol) begin rx = {rx[14:0], sdo}; nbits++; end
        else pulses++;
      end
    end
    if (sdo_oe && prev_oe && sdo != prev_sdo && !(sck != prev_sck && sck != cfg_cpol))
      bad_sdo++;
    prev_sck = sck; prev_sdo = sdo; prev_oe = sdo_oe; prev_low = low;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // {inject, cpol, mls, half_div, data}
  localparam logic [41:0] VEC [4] = '{
    {1'b0, 1'b0, 8'd0,   16'd4, 16'hA55A},
    {1'b0, 1'b1, 8'd7,   16'd2, 16'h8001},
    {1'b1, 1'b0, 8'd148, 16'd6, 16'h3C96},
    {1'b0, 1'b1, 8'd255, 16'd5, 16'hFFFE}
  };

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(!drdy_oe && !sdo_oe, "R1 enables", {drdy_oe, sdo_oe}, 0);
    chk(!meas_start && !res_ready && !setup_mode, "R1 strobes", {meas_start, res_ready, setup_mode}, 0);
    chk(sck == cfg_cpol, "R1 sck rest", sck, cfg_cpol);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int v = 0; v < 4; v++) begin
      logic [15:0] exp_d;
      int exp_half, exp_gap, inj_left, tmo;
      bit injected;
      exp_d = VEC[v][15:0];
      cfg_half_div = VEC[v][31:16];
      cfg_mls = VEC[v][39:32];
      cfg_cpol = VEC[v][40];
      stub_word = exp_d;
      exp_half = (VEC[v][31:16] < MIN_HALF) ? MIN_HALF : int'(VEC[v][31:16]);
      exp_gap = (10 + 4 * int'(VEC[v][39:32])) * GAP_TICK;
      repeat (3) @(negedge clk);
      clear_stats();
      req_n = 1'b0;
      repeat (40) @(negedge clk);
      req_n = 1'b1;
      injected = 0; inj_left = 0; tmo = 0;
      while (!(drive_seen && !drdy_oe) && tmo < 20000) begin
        @(negedge clk); tmo++;
        if (VEC[v][41] && !injected && gap_cnt == 20) begin req_n = 1'b0; injected = 1; inj_left = 40; end
        if (inj_left > 0) begin inj_left--; if (inj_left == 0) req_n = 1'b1; end
      end
      repeat (60) @(negedge clk);
      chk(mstarts == 1, "R2 one start per request", mstarts, 1);
      chk(ready_at_valid && !res_ready, "R3 handshake", {ready_at_valid, res_ready}, 2);
      chk(rx == exp_d, "R5 received word", rx, exp_d);
      chk(nbytes == 2 && nbits == 16, "R5 byte count", nbytes, 2);
      chk(gap_cnt >= exp_gap - GAP_TICK && gap_cnt <= exp_gap + GAP_TICK, "R6 gap", gap_cnt, exp_gap);
      chk(!drdy_oe && !sdo_oe, "R7 released", {drdy_oe, sdo_oe}, 0);
      chk(bad_sdo == 0 && pulses == 16, "R8 data edges", bad_sdo * 100 + pulses, 16);
      chk(sck == cfg_cpol, "R8 rest level", sck, cfg_cpol);
      chk(hmin == exp_half && hmax == exp_half, "R9 half period", hmin * 1000 + hmax, exp_half * 1001);
      if (VEC[v][41]) chk(injected && mstarts == 1, "R10 request during transfer", mstarts, 1);
    end

    // R2 short pulse ignored
    clear_stats();
    req_n = 1'b0;
    repeat (8) @(negedge clk);
    req_n = 1'b1;
    repeat (100) @(negedge clk);
    chk(mstarts == 0 && !drive_seen, "R2 short pulse ignored", mstarts, 0);

    // R4 setup mode: request still low when result arrives
    clear_stats();
    stub_word = 16'h1234;
    req_n = 1'b0;
    repeat (200) @(negedge clk);
    chk(setup_mode == 1'b1, "R4 setup entered", setup_mode, 1);
    chk(!drive_seen && mstarts == 1, "R4 nothing sent", drive_seen, 0);
    req_n = 1'b1;
    repeat (200) @(negedge clk);
    chk(setup_mode == 1'b1 && !drive_seen, "R4 setup sticky", setup_mode, 1);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(setup_mode == 1'b0, "R1 reset clears setup", setup_mode, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule